// File: doc/BRIEF.md
# Ordered Store Queue With Selectable Memory Ordering

This block sits between one core's load/store port and a shared single-port memory. Stores are captured in an eight-slot queue, so the core moves on at once while the slow memory write happens later. A load looks in the queue first. If one or more queued stores target the same address, the data of the youngest of them is returned without touching memory. A load that finds nothing in the queue becomes a memory read and may overtake older queued stores to other addresses. Only the write-then-read order is relaxed this way.

A two-bit ordering input selects one of three behaviours. In strict mode every operation completes in memory before the next one is taken. In store-ordered mode the queue drains oldest first. In relaxed-store mode the queue drains the oldest entry tagged as a fast hit before any untagged entry. A barrier input holds off the core until the queue and the memory port are both idle. The memory side is a ready/valid request channel with at most one request outstanding, and a response strobe for each request.

Top module: `store_order_buffer`

## Requirements
- R1: After reset the store and load ports are ready, no memory request is presented and no load result is signalled.
- R2: The queue accepts up to DEPTH (8) stores while memory is not accepting requests. With DEPTH entries held, `st_ready_o` is low.
- R3: A load whose address equals one or more queued stores returns the data of the youngest such store on `ld_rvalid_o` one cycle after acceptance, without a memory read.
- R4: A load that matches no queued store issues a memory read (`mem_req_write_o` = 0). Its data appears on `ld_rvalid_o` one cycle after `mem_resp_valid_i`.
- R5: With `order_sel_i` = 1 (store-ordered), queued stores are written to memory strictly in the order they were accepted.
- R6: With `order_sel_i` = 2 (relaxed-store), each drain takes the oldest queued entry whose `st_fast_i` tag was 1. If no such entry exists, it takes the oldest entry.
- R7: With `order_sel_i` other than 0, a pending load read is presented to memory ahead of any queued store.
- R8: With `order_sel_i` = 0 (strict), a store is taken only when the queue is empty, the memory port is idle, no load is pending and `ld_valid_i` is low. A load is taken only when the queue is empty and the memory port is idle. So no read reaches memory while a store is queued.
- R9: While `barrier_i` is high and the queue or the memory port is busy, both `st_ready_o` and `ld_ready_o` are low.
- R10: After a memory request is accepted, no new request is presented until `mem_resp_valid_i` has been seen.
- R11: In the store-buffering pattern, where this core stores X then loads Y and another agent writes Y then reads X, both reads return 0 only in modes 1 and 2, never in mode 0.
- R12: If a load and a store are accepted in the same cycle, the load counts as older and does not receive that store's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_sel_i | input | 2 | 0 strict, 1 store-ordered, 2 relaxed-store, 3 as 1; change only when idle |
| barrier_i | input | 1 | Hold the core until queue and memory port are idle |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle when high with valid |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| st_fast_i | input | 1 | Drain hint: entry expected to hit quickly |
| ld_valid_i | input | 1 | Load request |
| ld_ready_o | output | 1 | Load accepted this cycle when high with valid |
| ld_addr_i | input | AW | Load address |
| ld_rvalid_o | output | 1 | One-cycle strobe: load data valid |
| ld_rdata_o | output | DW | Load data |
| mem_req_valid_o | output | 1 | Memory request presented |
| mem_req_ready_i | input | 1 | Memory takes the request |
| mem_req_write_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | AW | Request address |
| mem_req_wdata_o | output | DW | Write data |
| mem_resp_valid_i | input | 1 | Completion strobe for the outstanding request |
| mem_resp_rdata_i | input | DW | Read data with the completion strobe |

## Verification
The checker watches, on every cycle, the ordering invariants that can be seen from a single cycle or one step of history. These are that the queue never overflows, that a full queue refuses stores, and that strict mode never sends a read while a store is queued. They also cover load-before-drain priority in the relaxed modes, the barrier hold, and the single outstanding request. What the properties cannot show is the order in which entries reach memory, youngest-match forwarding data, and the end-to-end store-buffering outcome. The bench scenarios establish these by logging every memory operation, comparing load data through a scoreboard, and letting a second agent act on memory at the moment the core's read is granted.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        ORD_STRICT  = 2'd0,
        ORD_STORES  = 2'd1,
        ORD_RELAXED = 2'd2,
        ORD_SPARE   = 2'd3
    } ord_mode_e;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_MISS = 2'd1,
        LD_WAIT = 2'd2
    } ld_state_e;

    function automatic logic mode_is(input logic [1:0] sel, input ord_mode_e m);
        return sel == m;
    endfunction

endpackage

// File: rtl/sbuf_entries.sv
module sbuf_entries #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [AW-1:0]   push_addr,
    input  logic [DW-1:0]   push_data,
    input  logic            push_fast,
    input  logic            pop,
    input  logic [IDXW-1:0] pop_idx,
    input  logic            pso_order,
    input  logic [AW-1:0]   look_addr,
    output logic [CNTW-1:0] fill,
    output logic            full,
    output logic            hit,
    output logic [DW-1:0]   hit_data,
    output logic [IDXW-1:0] sel_idx,
    output logic [AW-1:0]   sel_addr,
    output logic [DW-1:0]   sel_data
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          fast;
    } slot_t;

    slot_t           slots   [DEPTH];
    slot_t           slots_n [DEPTH];
    logic [CNTW-1:0] cnt, cnt_n, wr_pos;
    logic [DEPTH-1:0] live, match, fast_live;

    // per-slot status vectors, oldest entry at index 0
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign live[g]      = CNTW'(g) < cnt;
        assign match[g]     = live[g] && (slots[g].addr == look_addr);
        assign fast_live[g] = live[g] && slots[g].fast;
    end

    // compacting update: remove at pop_idx, append behind the survivors
    always_comb begin
        slots_n = slots;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDXW'(i) >= pop_idx) slots_n[i] = slots[i+1];
            end
        end
        wr_pos = cnt - CNTW'(pop);
        if (push) begin
            slots_n[wr_pos[IDXW-1:0]] = '{addr: push_addr, data: push_data, fast: push_fast};
        end
        cnt_n = cnt + CNTW'(push) - CNTW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_n;
        slots <= slots_n;
    end

    // youngest match wins: later indices overwrite earlier ones
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_data = slots[i].data;
            end
        end
    end

    // drain choice: head, or oldest fast-tagged entry in relaxed mode
    always_comb begin
        logic found;
        found   = 1'b0;
        sel_idx = '0;
        if (pso_order) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!found && fast_live[i]) begin
                    sel_idx = IDXW'(i);
                    found   = 1'b1;
                end
            end
        end
    end

    assign sel_addr = slots[sel_idx].addr;
    assign sel_data = slots[sel_idx].data;
    assign fill     = cnt;
    assign full     = cnt == CNTW'(DEPTH);

endmodule

// File: rtl/sbuf_memport.sv
module sbuf_memport #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drain_first,
    input  logic          rd_want,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_want,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_resp_valid,
    output logic          rd_grant,
    output logic          wr_grant,
    output logic          busy,
    output logic          rd_done
);

    logic outstanding, out_is_rd, pick_rd, fire;

    assign pick_rd       = rd_want && (!wr_want || !drain_first);
    assign mem_req_valid = !outstanding && (rd_want || wr_want);
    assign mem_req_write = !pick_rd;
    assign mem_req_addr  = pick_rd ? rd_addr : wr_addr;
    assign mem_req_wdata = wr_data;
    assign fire          = mem_req_valid && mem_req_ready;
    assign rd_grant      = fire && pick_rd;
    assign wr_grant      = fire && !pick_rd;
    assign busy          = outstanding;
    assign rd_done       = outstanding && out_is_rd && mem_resp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            out_is_rd   <= 1'b0;
        end else if (fire) begin
            outstanding <= 1'b1;
            out_is_rd   <= pick_rd;
        end else if (outstanding && mem_resp_valid) begin
            outstanding <= 1'b0;
        end
    end

endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    order_sel_i,
    input  logic          barrier_i,
    input  logic          st_valid_i,
    output logic          st_ready_o,
    input  logic [AW-1:0] st_addr_i,
    input  logic [DW-1:0] st_data_i,
    input  logic          st_fast_i,
    input  logic          ld_valid_i,
    output logic          ld_ready_o,
    input  logic [AW-1:0] ld_addr_i,
    output logic          ld_rvalid_o,
    output logic [DW-1:0] ld_rdata_o,
    output logic          mem_req_valid_o,
    input  logic          mem_req_ready_i,
    output logic          mem_req_write_o,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [DW-1:0] mem_req_wdata_o,
    input  logic          mem_resp_valid_i,
    input  logic [DW-1:0] mem_resp_rdata_i
);
    import sbuf_pkg::*;

    localparam int IDXW = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            strict_mode, relaxed_mode;
    logic [CNTW-1:0] fill_w;
    logic            full_w, hit_w;
    logic [DW-1:0]   hit_data_w, sel_data_w;
    logic [IDXW-1:0] sel_idx_w;
    logic [AW-1:0]   sel_addr_w;
    logic            mem_busy_w, rd_grant_w, wr_grant_w, rd_done_w;
    logic            ld_miss_w, drained, blocked, st_fire, ld_fire;

    ld_state_e       lst;
    logic [AW-1:0]   ld_addr_q;
    logic            rvalid_q;
    logic [DW-1:0]   rdata_q;

    assign strict_mode  = mode_is(order_sel_i, ORD_STRICT);
    assign relaxed_mode = mode_is(order_sel_i, ORD_RELAXED);
    assign ld_miss_w    = lst == LD_MISS;
    assign drained      = (fill_w == '0) && !mem_busy_w;
    assign blocked      = barrier_i && !drained;

    assign ld_ready_o = (lst == LD_IDLE) && !blocked && (!strict_mode || drained);
    assign st_ready_o = !full_w && !blocked &&
                        (!strict_mode || (drained && lst == LD_IDLE && !ld_valid_i));
    assign st_fire    = st_valid_i && st_ready_o;
    assign ld_fire    = ld_valid_i && ld_ready_o;

    sbuf_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
        .clk       (clk),
        .rst       (rst),
        .push      (st_fire),
        .push_addr (st_addr_i),
        .push_data (st_data_i),
        .push_fast (st_fast_i),
        .pop       (wr_grant_w),
        .pop_idx   (sel_idx_w),
        .pso_order (relaxed_mode),
        .look_addr (ld_addr_i),
        .fill      (fill_w),
        .full      (full_w),
        .hit       (hit_w),
        .hit_data  (hit_data_w),
        .sel_idx   (sel_idx_w),
        .sel_addr  (sel_addr_w),
        .sel_data  (sel_data_w)
    );

    sbuf_memport #(.AW(AW), .DW(DW)) u_memport (
        .clk            (clk),
        .rst            (rst),
        .drain_first    (strict_mode),
        .rd_want        (ld_miss_w),
        .rd_addr        (ld_addr_q),
        .wr_want        (fill_w != '0),
        .wr_addr        (sel_addr_w),
        .wr_data        (sel_data_w),
        .mem_req_valid  (mem_req_valid_o),
        .mem_req_ready  (mem_req_ready_i),
        .mem_req_write  (mem_req_write_o),
        .mem_req_addr   (mem_req_addr_o),
        .mem_req_wdata  (mem_req_wdata_o),
        .mem_resp_valid (mem_resp_valid_i),
        .rd_grant       (rd_grant_w),
        .wr_grant       (wr_grant_w),
        .busy           (mem_busy_w),
        .rd_done        (rd_done_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lst       <= LD_IDLE;
            ld_addr_q <= '0;
            rvalid_q  <= 1'b0;
            rdata_q   <= '0;
        end else begin
            rvalid_q <= 1'b0;
            case (lst)
                LD_IDLE: if (ld_fire) begin
                    if (hit_w) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= hit_data_w;
                    end else begin
                        ld_addr_q <= ld_addr_i;
                        lst       <= LD_MISS;
                    end
                end
                LD_MISS: if (rd_grant_w) lst <= LD_WAIT;
                LD_WAIT: if (rd_done_w) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= mem_resp_rdata_i;
                    lst      <= LD_IDLE;
                end
                default: lst <= LD_IDLE;
            endcase
        end
    end

    assign ld_rvalid_o = rvalid_q;
    assign ld_rdata_o  = rdata_q;

endmodule

// File: rtl/store_order_buffer_chk.sv
module store_order_buffer_chk #(
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      order_sel_i,
    input logic            barrier_i,
    input logic            st_ready_o,
    input logic            ld_ready_o,
    input logic            mem_req_valid_o,
    input logic            mem_req_ready_i,
    input logic            mem_req_write_o,
    input logic [CNTW-1:0] fill_w,
    input logic            mem_busy_w,
    input logic            ld_miss_w
);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        fill_w <= CNTW'(DEPTH));

    assert_full_refuses_R2: assert property (@(posedge clk) disable iff (rst)
        (fill_w == CNTW'(DEPTH)) |-> !st_ready_o);

    assert_strict_no_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (order_sel_i == 2'd0 && mem_req_valid_o && !mem_req_write_o) |-> (fill_w == '0));

    assert_load_before_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (order_sel_i != 2'd0 && mem_req_valid_o && ld_miss_w) |-> !mem_req_write_o);

    assert_barrier_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (barrier_i && (fill_w != '0 || mem_busy_w)) |-> (!st_ready_o && !ld_ready_o));

    assert_single_request_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

endmodule

bind store_order_buffer store_order_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .order_sel_i     (order_sel_i),
    .barrier_i       (barrier_i),
    .st_ready_o      (st_ready_o),
    .ld_ready_o      (ld_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_write_o (mem_req_write_o),
    .fill_w          (fill_w),
    .mem_busy_w      (mem_busy_w),
    .ld_miss_w       (ld_miss_w)
);

// File: tb/store_order_buffer_test.sv
`timescale 1ns/1ps
module store_order_buffer_test;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    order_sel = 2'd1;
    logic          barrier = 1'b0;
    logic          st_valid = 1'b0, st_fast = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          st_ready, ld_ready, ld_rvalid;
    logic [DW-1:0] ld_rdata;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_gate = 1'b1;
    logic          mem_resp_valid;
    logic [DW-1:0] mem_resp_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    store_order_buffer #(.DEPTH(8), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .order_sel_i(order_sel), .barrier_i(barrier),
        .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
        .st_data_i(st_data), .st_fast_i(st_fast),
        .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_addr_i(ld_addr),
        .ld_rvalid_o(ld_rvalid), .ld_rdata_o(ld_rdata),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_gate),
        .mem_req_write_o(mem_req_write), .mem_req_addr_o(mem_req_addr),
        .mem_req_wdata_o(mem_req_wdata), .mem_resp_valid_i(mem_resp_valid),
        .mem_resp_rdata_i(mem_resp_rdata)
    );

    // ---------------- memory model with a second agent ----------------
    logic [DW-1:0] mem [256];
    logic          pend;
    int            pend_cnt;
    logic [DW-1:0] rd_hold;
    int            overlap_err = 0;
    bit            oplog [$];
    logic [AW-1:0] wlog  [$];
    bit            agent_arm = 1'b0;
    logic [AW-1:0] agent_x = '0, agent_y = '0;
    logic [DW-1:0] agent_r = '0;

    always @(posedge clk) begin
        mem_resp_valid <= 1'b0;
        if (rst) begin
            for (int i = 0; i < 256; i++)
                mem[i] <= (i >= 128) ? 32'h0 : 32'h1000_0000 + 32'(i);
            pend           <= 1'b0;
            pend_cnt       <= 0;
            mem_resp_rdata <= '0;
        end else begin
            if (pend) begin
                if (pend_cnt == 1) begin
                    mem_resp_valid <= 1'b1;
                    mem_resp_rdata <= rd_hold;
                    pend           <= 1'b0;
                end else pend_cnt <= pend_cnt - 1;
            end
            if (mem_req_valid && mem_gate) begin
                if (pend) overlap_err <= overlap_err + 1;
                oplog.push_back(mem_req_write);
                pend     <= 1'b1;
                pend_cnt <= LAT;
                if (mem_req_write) begin
                    mem[mem_req_addr[7:0]] <= mem_req_wdata;
                    wlog.push_back(mem_req_addr);
                end else begin
                    rd_hold <= mem[mem_req_addr[7:0]];
                    if (agent_arm && mem_req_addr == agent_y) begin
                        mem[agent_y[7:0]] <= 32'd1;
                        agent_r <= mem[agent_x[7:0]];
                    end
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [DW-1:0] exp_d   [$];
    string         exp_tag [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && ld_rvalid) begin
            if (exp_d.size() == 0) chk(1'b0, "R3/R4 unexpected load result", ld_rdata, 32'h0);
            else begin
                logic [DW-1:0] e;
                string t;
                e = exp_d.pop_front();
                t = exp_tag.pop_front();
                chk(ld_rdata == e, t, ld_rdata, e);
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_fast = f;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        exp_d.push_back(e); exp_tag.push_back(tag);
        #1;
        while (!ld_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_order(input logic [AW-1:0] e [$], input string tag);
        bit ok;
        logic [31:0] act, exv;
        ok = (wlog.size() == e.size());
        act = 32'(wlog.size()); exv = 32'(e.size());
        if (ok) begin
            for (int i = 0; i < e.size(); i++) begin
                if (ok && wlog[i] != e[i]) begin
                    ok = 1'b0; act = 32'(wlog[i]); exv = 32'(e[i]);
                end
            end
        end
        chk(ok, tag, act, exv);
    endtask

    task automatic clear_logs();
        oplog.delete();
        wlog.delete();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(st_ready == 1'b1, "R1 st_ready after reset", 32'(st_ready), 32'h1);
        chk(ld_ready == 1'b1, "R1 ld_ready after reset", 32'(ld_ready), 32'h1);
        chk(mem_req_valid == 1'b0, "R1 no memory request after reset", 32'(mem_req_valid), 32'h0);
        chk(ld_rvalid == 1'b0, "R1 no load result after reset", 32'(ld_rvalid), 32'h0);

        // R3 youngest-match forwarding with memory closed
        order_sel = 2'd1;
        mem_gate  = 1'b0;
        clear_logs();
        do_store(16'h0010, 32'd111, 1'b0);
        do_store(16'h0010, 32'd222, 1'b0);
        do_store(16'h0011, 32'd333, 1'b0);
        do_load(16'h0010, 32'd222, "R3 youngest matching store forwarded");
        do_load(16'h0011, 32'd333, "R3 single matching store forwarded");
        idle(3);
        chk(exp_d.size() == 0, "R3 forwarded without memory", 32'(exp_d.size()), 32'h0);
        chk(oplog.size() == 0, "R3 no memory read on hit", 32'(oplog.size()), 32'h0);

        // R7 load miss goes ahead of queued stores; R5 drain order; R4 miss data
        do_load(16'h0020, 32'h1000_0020, "R4 miss returns memory data");
        mem_gate = 1'b1;
        idle(40);
        chk(oplog.size() > 0 && oplog[0] == 1'b0, "R7 first memory op is the load read",
            (oplog.size() > 0) ? 32'(oplog[0]) : 32'hFFFF, 32'h0);
        check_order('{16'h0010, 16'h0010, 16'h0011}, "R5 store-ordered drain sequence");
        do_load(16'h0010, 32'd222, "R4 read after drain sees youngest store");
        idle(20);

        // R2 queue full
        clear_logs();
        mem_gate = 1'b0;
        for (int i = 0; i < 8; i++) do_store(16'h0030 + 16'(i), 32'(i), 1'b0);
        @(negedge clk); #1;
        chk(st_ready == 1'b0, "R2 full queue refuses stores", 32'(st_ready), 32'h0);
        mem_gate = 1'b1;
        idle(60);
        check_order('{16'h0030, 16'h0031, 16'h0032, 16'h0033,
                      16'h0034, 16'h0035, 16'h0036, 16'h0037}, "R5 eight stores drain in order");

        // R6 relaxed-store drain: fast-tagged entries first
        order_sel = 2'd2;
        clear_logs();
        mem_gate = 1'b0;
        do_store(16'h0040, 32'd1, 1'b0);
        do_store(16'h0041, 32'd2, 1'b1);
        do_store(16'h0042, 32'd3, 1'b0);
        do_store(16'h0043, 32'd4, 1'b1);
        mem_gate = 1'b1;
        idle(40);
        check_order('{16'h0041, 16'h0043, 16'h0040, 16'h0042}, "R6 fast entries drain first");

        // R12 same-cycle load and store
        order_sel = 2'd1;
        mem_gate  = 1'b0;
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 16'h0050;
        st_valid = 1'b1; st_addr = 16'h0050; st_data = 32'd999; st_fast = 1'b0;
        exp_d.push_back(32'h1000_0050); exp_tag.push_back("R12 same-cycle load is older");
        #1;
        chk(ld_ready && st_ready, "R12 both ports ready", {30'h0, ld_ready, st_ready}, 32'h3);
        @(posedge clk); #1;
        ld_valid = 1'b0; st_valid = 1'b0;
        mem_gate = 1'b1;
        idle(30);
        do_load(16'h0050, 32'd999, "R12 store reaches memory afterwards");
        idle(20);

        // R9 barrier
        mem_gate = 1'b0;
        do_store(16'h0060, 32'd7, 1'b0);
        @(negedge clk);
        barrier = 1'b1;
        #1;
        chk(!st_ready && !ld_ready, "R9 barrier holds both ports", {30'h0, ld_ready, st_ready}, 32'h0);
        mem_gate = 1'b1;
        idle(20); #1;
        chk(st_ready && ld_ready, "R9 barrier releases when idle", {30'h0, ld_ready, st_ready}, 32'h3);
        barrier = 1'b0;

        // R8 strict mode
        order_sel = 2'd0;
        mem_gate  = 1'b0;
        do_store(16'h0070, 32'd5, 1'b0);
        @(negedge clk); #1;
        chk(!st_ready && !ld_ready, "R8 strict stalls while store pending",
            {30'h0, ld_ready, st_ready}, 32'h0);
        mem_gate = 1'b1;
        idle(20);
        clear_logs();
        mem_gate = 1'b0;
        fork
            begin
                do_store(16'h0072, 32'd6, 1'b0);
                do_load(16'h0073, 32'h1000_0073, "R8 strict load data");
            end
            begin
                idle(6);
                mem_gate = 1'b1;
            end
        join
        idle(20);
        chk(oplog.size() == 2 && oplog[0] == 1'b1 && oplog[1] == 1'b0,
            "R8 strict write completes before read", 32'(oplog.size()), 32'h2);

        // R11 store-buffering pattern in each mode
        for (int m = 0; m < 3; m++) begin
            order_sel = 2'(m);
            agent_x   = 16'h0080 + 16'(2 * m);
            agent_y   = 16'h0081 + 16'(2 * m);
            agent_r   = 32'hDEAD;
            agent_arm = 1'b1;
            mem_gate  = 1'b0;
            fork
                begin
                    do_store(agent_x, 32'd1, 1'b0);
                    do_load(agent_y, 32'd0, "R11 core read of Y");
                end
                begin
                    idle(6);
                    mem_gate = 1'b1;
                end
            join
            idle(30);
            agent_arm = 1'b0;
            if (m == 0)
                chk(agent_r == 32'd1, "R11 strict mode forbids both-zero", agent_r, 32'd1);
            else
                chk(agent_r == 32'd0, "R11 relaxed write-read order gives both-zero", agent_r, 32'd0);
        end

        chk(overlap_err == 0, "R10 one outstanding memory request", 32'(overlap_err), 32'h0);
        chk(exp_d.size() == 0, "R4 every load answered", 32'(exp_d.size()), 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule